// File: doc/BRIEF.md
# Paged Frame Buffer Host Window

This block lets a host processor reach a square frame store of pixels through a narrow memory window. The image holds 2^SIDE_LOG2 by 2^SIDE_LOG2 pixels. The host window is 2^WIN_LOG2 bytes, which is a quarter of the image at the default sizes, so a page number picks which part of the image appears in the window. The full image offset is the page number followed by the window offset. A rotate bit controls how that offset maps onto the image. With rotate clear, consecutive offsets move along a row. With rotate set, consecutive offsets move down a column.

The window responds on the host bus only while its enable bit is set. This lets several copies of the block share one address range. Software enables the copy it wants to use and leaves the others off. The base address of the window is one of four fixed values, chosen by a board strap and a bank bit. The control registers sit at two fixed addresses on the same bus and always decode. They cannot be read back: a read of either control address returns an external status byte. A separate display read port scans the stored image at all times, whatever the window state. The pixel store is a dual-port RAM that synthesis can map to block memory.

Top module: `fb_host_window`

## Requirements
- R1: After reset, page 0 is selected, rotate is off, the bank bit is 0 and the window is disabled. In the first cycle after reset, `bus_rvalid` is 0 and `bus_rdata` is 0.
- R2: A write to the first control address (CTRL0_ADDR) sets the page number from data bits [PAGE_BITS-1:0]. The page number changes on no other event.
- R3: With rotate clear, let F = page*2^WIN_LOG2 + window offset. F addresses the pixel with x = F mod 2^SIDE_LOG2 and y = F div 2^SIDE_LOG2.
- R4: Rotate is bit 4 of a CTRL0_ADDR write. With rotate set, F addresses the pixel with x = F div 2^SIDE_LOG2 and y = F mod 2^SIDE_LOG2.
- R5: The window enable is bit 1 of a write to the second control address (CTRL1_ADDR). While it is clear, a window write leaves the store unchanged and a window read gets no response.
- R6: The bank bit is bit 0 of a CTRL1_ADDR write. The window base is 0xA0000 for bank 0 with the strap low, and 0xB0000 for bank 0 with the strap high. It is 0xD0000 for bank 1 with the strap low, and 0xE0000 for bank 1 with the strap high. Accesses outside the selected window are ignored.
- R7: `bus_rvalid` is high exactly one cycle after a read strobe to an address that decodes, and it carries the data in `bus_rdata`. In every other cycle `bus_rvalid` is 0 and `bus_rdata` is 0.
- R8: The control registers cannot be read back. A read of either control address returns the `status_in` value sampled at the strobe, whether or not the window is enabled.
- R9: `disp_pix` gives the pixel at (`disp_x`, `disp_y`) one cycle later. It is not affected by the page, the rotate bit or the window enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_hi | input | 1 | Board strap; chooses the upper base of each pair |
| bus_addr | input | ADDR_W | Host byte address |
| bus_wdata | input | PIX_W | Host write data |
| bus_we | input | 1 | Host write strobe |
| bus_re | input | 1 | Host read strobe |
| bus_rdata | output | PIX_W | Host read data, zero when not valid |
| bus_rvalid | output | 1 | Read response, one cycle after the strobe |
| status_in | input | PIX_W | Status byte returned on control-port reads |
| disp_x | input | SIDE_LOG2 | Display scan column |
| disp_y | input | SIDE_LOG2 | Display scan row |
| disp_pix | output | PIX_W | Pixel at the scan position, one cycle later |

## Verification
The bench builds the block at its defaults: a 32x32 image with a 256-byte window. That gives four pages, the same page split as a full-size frame, and the whole 1024-pixel store can be swept completely. Every pixel is written through the row-ordered window and then checked on the display port. Every window offset of every page is read back with rotate set, against a transposed index computed in the bench. All four strap and bank combinations are checked against all four candidate bases, so a fault in the base selection cannot go unseen.

// File: rtl/fb_win_pkg.sv
package fb_win_pkg;
  // Control field positions; software depends on these.
  localparam int ROT_POS  = 4;  // in control word 0
  localparam int BANK_POS = 0;  // in control word 1
  localparam int WEN_POS  = 1;  // in control word 1

  typedef enum logic {
    SRC_PIXEL  = 1'b0,
    SRC_STATUS = 1'b1
  } rd_src_e;
endpackage

// File: rtl/fb_ctrl_regs.sv
module fb_ctrl_regs
  import fb_win_pkg::*;
#(
  parameter int                PAGE_BITS  = 2,
  parameter int                DATA_W     = 8,
  parameter int                ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] CTRL0_ADDR = 20'h00300,
  parameter logic [ADDR_W-1:0] CTRL1_ADDR = 20'h00301
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 we,
  output logic [PAGE_BITS-1:0] page_sel,
  output logic                 rotate,
  output logic                 bank_hi,
  output logic                 win_en,
  output logic                 ctrl_hit
);
  logic sel0, sel1;
  logic unused_wdata;

  assign sel0     = (addr == CTRL0_ADDR);
  assign sel1     = (addr == CTRL1_ADDR);
  assign ctrl_hit = sel0 | sel1;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_sel <= '0;
      rotate   <= 1'b0;
      bank_hi  <= 1'b0;
      win_en   <= 1'b0;
    end else if (we) begin
      if (sel0) begin
        page_sel <= wdata[PAGE_BITS-1:0];
        rotate   <= wdata[ROT_POS];
      end
      if (sel1) begin
        bank_hi <= wdata[BANK_POS];
        win_en  <= wdata[WEN_POS];
      end
    end
  end
endmodule

// File: rtl/fb_addr_map.sv
module fb_addr_map #(
  parameter int                ADDR_W    = 20,
  parameter int                SIDE_LOG2 = 5,
  parameter int                WIN_LOG2  = 8,
  parameter logic [ADDR_W-1:0] BASE_LL   = 20'hA0000,
  parameter logic [ADDR_W-1:0] BASE_LH   = 20'hB0000,
  parameter logic [ADDR_W-1:0] BASE_HL   = 20'hD0000,
  parameter logic [ADDR_W-1:0] BASE_HH   = 20'hE0000,
  localparam int IDX_W     = 2 * SIDE_LOG2,
  localparam int PAGE_BITS = IDX_W - WIN_LOG2
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [PAGE_BITS-1:0] page_sel,
  input  logic                 rotate,
  input  logic                 bank_hi,
  input  logic                 strap_hi,
  input  logic                 win_en,
  output logic                 win_hit,
  output logic [IDX_W-1:0]     pix_idx
);
  logic [ADDR_W-1:0] base;
  logic [IDX_W-1:0]  flat;
  logic [IDX_W-1:0]  swapped;

  always_comb begin
    unique case ({bank_hi, strap_hi})
      2'b00:   base = BASE_LL;
      2'b01:   base = BASE_LH;
      2'b10:   base = BASE_HL;
      default: base = BASE_HH;
    endcase
  end

  assign win_hit = win_en && (addr[ADDR_W-1:WIN_LOG2] == base[ADDR_W-1:WIN_LOG2]);
  assign flat    = {page_sel, addr[WIN_LOG2-1:0]};

  // Transposed index: low half of the offset becomes the row.
  genvar g;
  generate
    for (g = 0; g < SIDE_LOG2; g++) begin : g_swap
      assign swapped[g]             = flat[g + SIDE_LOG2];
      assign swapped[g + SIDE_LOG2] = flat[g];
    end
  endgenerate

  assign pix_idx = rotate ? swapped : flat;
endmodule

// File: rtl/fb_pixel_ram.sv
module fb_pixel_ram #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [IDX_W-1:0]  b_idx,
  output logic [DATA_W-1:0] b_rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_idx] <= a_wdata;
    a_rdata <= mem[a_idx];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_idx];
  end
endmodule

// File: rtl/fb_host_window.sv
module fb_host_window
  import fb_win_pkg::*;
#(
  parameter int                PIX_W      = 8,
  parameter int                SIDE_LOG2  = 5,
  parameter int                WIN_LOG2   = 8,
  parameter int                ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] CTRL0_ADDR = 20'h00300,
  parameter logic [ADDR_W-1:0] CTRL1_ADDR = 20'h00301,
  parameter logic [ADDR_W-1:0] BASE_LL    = 20'hA0000,
  parameter logic [ADDR_W-1:0] BASE_LH    = 20'hB0000,
  parameter logic [ADDR_W-1:0] BASE_HL    = 20'hD0000,
  parameter logic [ADDR_W-1:0] BASE_HH    = 20'hE0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 strap_hi,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [PIX_W-1:0]     bus_wdata,
  input  logic                 bus_we,
  input  logic                 bus_re,
  output logic [PIX_W-1:0]     bus_rdata,
  output logic                 bus_rvalid,
  input  logic [PIX_W-1:0]     status_in,
  input  logic [SIDE_LOG2-1:0] disp_x,
  input  logic [SIDE_LOG2-1:0] disp_y,
  output logic [PIX_W-1:0]     disp_pix
);
  localparam int IDX_W     = 2 * SIDE_LOG2;
  localparam int PAGE_BITS = IDX_W - WIN_LOG2;

  logic [PAGE_BITS-1:0] page_sel;
  logic                 rotate, bank_hi, win_en, ctrl_hit, win_hit;
  logic [IDX_W-1:0]     pix_idx;
  logic [PIX_W-1:0]     ram_q, stat_q;
  logic                 rvalid_q;
  rd_src_e              src_q;

  fb_ctrl_regs #(
    .PAGE_BITS(PAGE_BITS), .DATA_W(PIX_W), .ADDR_W(ADDR_W),
    .CTRL0_ADDR(CTRL0_ADDR), .CTRL1_ADDR(CTRL1_ADDR)
  ) regs_i (
    .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
    .page_sel(page_sel), .rotate(rotate), .bank_hi(bank_hi),
    .win_en(win_en), .ctrl_hit(ctrl_hit)
  );

  fb_addr_map #(
    .ADDR_W(ADDR_W), .SIDE_LOG2(SIDE_LOG2), .WIN_LOG2(WIN_LOG2),
    .BASE_LL(BASE_LL), .BASE_LH(BASE_LH), .BASE_HL(BASE_HL), .BASE_HH(BASE_HH)
  ) map_i (
    .addr(bus_addr), .page_sel(page_sel), .rotate(rotate), .bank_hi(bank_hi),
    .strap_hi(strap_hi), .win_en(win_en), .win_hit(win_hit), .pix_idx(pix_idx)
  );

  fb_pixel_ram #(.DATA_W(PIX_W), .IDX_W(IDX_W)) ram_i (
    .clk(clk),
    .a_we(bus_we && win_hit && !ctrl_hit),
    .a_idx(pix_idx),
    .a_wdata(bus_wdata),
    .a_rdata(ram_q),
    .b_idx({disp_y, disp_x}),
    .b_rdata(disp_pix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      src_q    <= SRC_PIXEL;
      stat_q   <= '0;
    end else begin
      rvalid_q <= bus_re && (ctrl_hit || win_hit);
      src_q    <= ctrl_hit ? SRC_STATUS : SRC_PIXEL;
      if (bus_re && ctrl_hit) stat_q <= status_in;
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = !rvalid_q ? '0 : (src_q == SRC_STATUS) ? stat_q : ram_q;
endmodule

// File: rtl/fb_host_window_chk.sv
module fb_host_window_chk #(
  parameter int                PIX_W      = 8,
  parameter int                PAGE_BITS  = 2,
  parameter int                ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] CTRL0_ADDR = 20'h00300,
  parameter logic [ADDR_W-1:0] CTRL1_ADDR = 20'h00301
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic                 bus_re,
  input logic                 bus_rvalid,
  input logic [PIX_W-1:0]     bus_rdata,
  input logic [PIX_W-1:0]     status_in,
  input logic                 win_en,
  input logic [PAGE_BITS-1:0] page_sel
);
  logic is_ctrl;
  assign is_ctrl = (bus_addr == CTRL0_ADDR) || (bus_addr == CTRL1_ADDR);

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> !bus_rvalid);

  a_r2_page_only_by_write: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_we && bus_addr == CTRL0_ADDR) |-> $stable(page_sel));

  a_r5_no_reply_when_off: assert property (@(posedge clk) disable iff (rst)
    (bus_re && !win_en && !is_ctrl) |=> !bus_rvalid);

  a_r7_reply_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_re));

  a_r8_status_readback: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == CTRL0_ADDR) |=> (bus_rvalid && bus_rdata == $past(status_in)));
endmodule

bind fb_host_window fb_host_window_chk #(
  .PIX_W(PIX_W), .PAGE_BITS(PAGE_BITS), .ADDR_W(ADDR_W),
  .CTRL0_ADDR(CTRL0_ADDR), .CTRL1_ADDR(CTRL1_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
  .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .status_in(status_in),
  .win_en(win_en), .page_sel(page_sel)
);

// File: tb/fb_host_window_tb.sv
`timescale 1ns/1ps
module fb_host_window_tb_top;
  localparam int SIDE = 5;
  localparam int WINL = 8;
  localparam int W    = 1 << SIDE;
  localparam int NPIX = W * W;
  localparam logic [19:0] C0 = 20'h00300;
  localparam logic [19:0] C1 = 20'h00301;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_hi = 1'b0;
  logic [19:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [7:0]  bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  status_in = 8'h3C;
  logic [SIDE-1:0] disp_x = '0;
  logic [SIDE-1:0] disp_y = '0;
  logic [7:0]  disp_pix;

  int n_tests = 0;
  int n_fail  = 0;
  logic [19:0] bases [4];

  always #4 clk = ~clk;

  fb_host_window dut_i (
    .clk(clk), .rst(rst), .strap_hi(strap_hi), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .status_in(status_in),
    .disp_x(disp_x), .disp_y(disp_y), .disp_pix(disp_pix)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [19:0] a, output logic v, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    v = bus_rvalid; d = bus_rdata;
  endtask

  task automatic disp(input int x, input int y, output logic [7:0] d);
    @(negedge clk);
    disp_x = SIDE'(x); disp_y = SIDE'(y);
    @(negedge clk);
    d = disp_pix;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic v;
    logic [7:0] d;
    bases[0] = 20'hA0000; bases[1] = 20'hB0000;
    bases[2] = 20'hD0000; bases[3] = 20'hE0000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: quiet outputs, window off
    chk("R1 rvalid after reset", int'(bus_rvalid), 0);
    chk("R1 rdata after reset", int'(bus_rdata), 0);
    rd(bases[0] + 20'd7, v, d);
    chk("R1 window disabled after reset", int'(v), 0);
    // R8: status byte on control read, window off
    status_in = 8'hA7;
    rd(C0, v, d);
    chk("R8 status valid", int'(v), 1);
    chk("R8 status value", int'(d), 8'hA7);
    // R1: page 0 selected by default
    wr(C1, 8'h02);
    wr(bases[0] + 20'd3, 8'h5A);
    disp(3, 0, d);
    chk("R1 default page 0", int'(d), 8'h5A);

    // R2/R3/R9: fill every page in row order, sweep display
    for (int p = 0; p < 4; p++) begin
      wr(C0, 8'(p));
      for (int o = 0; o < (1 << WINL); o++)
        wr(bases[0] + 20'(o), pat(p * (1 << WINL) + o));
    end
    for (int y = 0; y < W; y++)
      for (int x = 0; x < W; x++) begin
        disp(x, y, d);
        chk("R3 R9 row-order pixel", int'(d), int'(pat(y * W + x)));
      end
    // R2: page select with row-order readback
    wr(C0, 8'h02);
    rd(bases[0] + 20'd5, v, d);
    chk("R2 page 2 valid", int'(v), 1);
    chk("R2 page 2 data", int'(d), int'(pat(2 * 256 + 5)));
    // R4/R7: rotated readback of the whole store
    for (int p = 0; p < 4; p++) begin
      wr(C0, 8'(8'h10 | p));
      for (int o = 0; o < (1 << WINL); o++) begin
        int f;
        f = p * (1 << WINL) + o;
        rd(bases[0] + 20'(o), v, d);
        chk("R7 rotated read valid", int'(v), 1);
        chk("R4 rotated read data", int'(d), int'(pat((f % W) * W + f / W)));
      end
    end
    // R4: rotated write lands transposed: F=1 -> x=0, y=1
    wr(C0, 8'h10);
    wr(bases[0] + 20'd1, 8'hC3);
    disp(0, 1, d);
    chk("R4 rotated write", int'(d), 8'hC3);
    disp(1, 0, d);
    chk("R4 row neighbour untouched", int'(d), int'(pat(1)));

    // R5: disabled window ignores writes and reads
    wr(C0, 8'h00);
    wr(C1, 8'h00);
    wr(bases[0] + 20'd9, 8'hEE);
    disp(9, 0, d);
    chk("R5 write ignored when off", int'(d), int'(pat(9)));
    rd(bases[0] + 20'd9, v, d);
    chk("R5 read silent when off", int'(v), 0);
    chk("R7 rdata zero without reply", int'(d), 0);
    status_in = 8'h19;
    rd(C1, v, d);
    chk("R8 status via second port", int'(d), 8'h19);
    // R9: display unaffected by page, rotate and enable
    wr(C0, 8'h13);
    disp(4, 6, d);
    chk("R9 display independent", int'(d), int'(pat(6 * W + 4)));

    // R6: base decode for each bank/strap pair
    wr(C0, 8'h00);
    for (int s = 0; s < 4; s++) begin
      strap_hi = s[0];
      wr(C1, 8'(8'h02 | (s >> 1)));
      for (int b = 0; b < 4; b++) begin
        rd(bases[b] + 20'd2, v, d);
        chk("R6 base decode", int'(v), (b == s) ? 1 : 0);
        if (b == s) chk("R6 base data", int'(d), int'(pat(2)));
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule